// File: doc/BRIEF.md
# I/Q Imbalance Corrector

This block removes gain and quadrature-phase mismatch between the in-phase and quadrature rails of a stream of complex samples. Each valid sample is passed through a lower-triangular correction matrix: the I rail is scaled by (1 + A), and a fraction B of the incoming I is added onto the Q rail. Q itself is never scaled. A sets the magnitude correction and B sets the phase correction. The two are independent real numbers.

The block keeps no state from one sample to the next, so one instance can sit in either a transmit or a receive path. The two coefficients are written together as one word: A in the upper half and B in the lower half. Both then take effect in the same cycle. Each sample is computed entirely with one coefficient pair. Results are rounded to nearest, saturated to the sample width, and appear two cycles after the input with a matching valid flag.

Top module: `iq_balance_corr`

## Requirements
- R1: For each valid sample, out_i = sat(I + ((A*I + 2^14) >>> 15)), where A is signed Q1.15 and `>>>` is an arithmetic shift right. This rounds half toward plus infinity.
- R2: For each valid sample, out_q = sat(Q + ((B*I + 2^14) >>> 15)), where B is signed Q1.15. The incoming Q is added unscaled, so with I = 0 the output Q equals the input Q and the output I is 0.
- R3: Both outputs saturate to the signed 16-bit range [-32768, 32767] instead of wrapping.
- R4: When coef_load is high, coef_word[31:16] becomes A and coef_word[15:0] becomes B. Both are used from the next cycle on. A sample presented in the same cycle as the load still uses the previous pair.
- R5: out_valid is in_valid delayed by exactly two cycles, with one result per valid input in order. While out_valid is low, out_i and out_q hold their last values.
- R6: After reset, A = B = 0, out_valid = 0 and out_i = out_q = 0.
- R7: With A = B = 0 the output equals the input for every sample value.
- R8: Each result depends only on its own sample and the active coefficients. Back-to-back samples do not influence each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_load | input | 1 | Write strobe for the coefficient pair |
| coef_word | input | 32 | {A, B}, each signed Q1.15 |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | 16 | Corrected in-phase sample |
| out_q | output | 16 | Corrected quadrature sample |

## Verification
The identity pair (A = B = 0) is run with extreme and ordinary samples. This separates a pure delay from any scaling of either rail. Separate nonzero A and nonzero B runs, with I = 0 samples mixed in, show whether Q is ever scaled and whether the cross-feed comes only from I. Full-scale coefficients with full-scale I of both signs push the sums past the 16-bit range, which separates saturation from wrap-around. Values that land exactly on a half LSB expose the rounding direction. A load in the same cycle as a sample, followed by gapped and back-to-back traffic, checks the coefficient switch point, the latency and the output hold.

// File: rtl/iq_balance_corr.sv
module iq_balance_corr #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                coef_load,
  input  logic [2*CW-1:0]     coef_word,
  input  logic                in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  localparam int PW = DW + CW;
  localparam int SW = DW + 2;
  localparam logic signed [PW-1:0] HALF   = PW'(1) << (FRAC - 1);
  localparam logic signed [SW-1:0] MAXV   = SW'((1 << (DW - 1)) - 1);
  localparam logic signed [SW-1:0] MINV   = -SW'(1 << (DW - 1));

  logic signed [CW-1:0] a_act, b_act;
  logic                 s1_valid;
  logic signed [DW-1:0] s1_i, s1_q;
  logic signed [PW-1:0] s1_pa, s1_pb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_act <= '0;
      b_act <= '0;
    end else if (coef_load) begin
      a_act <= coef_word[2*CW-1:CW];
      b_act <= coef_word[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_i     <= '0;
      s1_q     <= '0;
      s1_pa    <= '0;
      s1_pb    <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_i  <= in_i;
        s1_q  <= in_q;
        s1_pa <= PW'(in_i) * PW'(a_act);
        s1_pb <= PW'(in_i) * PW'(b_act);
      end
    end
  end

  logic signed [PW-1:0] rnd_a, rnd_b;
  logic signed [SW-1:0] sum_i, sum_q;

  assign rnd_a = (s1_pa + HALF) >>> FRAC;
  assign rnd_b = (s1_pb + HALF) >>> FRAC;
  assign sum_i = SW'(s1_i) + SW'(rnd_a);
  assign sum_q = SW'(s1_q) + SW'(rnd_b);

  function automatic logic signed [DW-1:0] clip(input logic signed [SW-1:0] x);
    if (x > MAXV)      clip = MAXV[DW-1:0];
    else if (x < MINV) clip = MINV[DW-1:0];
    else               clip = x[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_i <= clip(sum_i);
        out_q <= clip(sum_q);
      end
    end
  end

  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> ($stable(out_i) && $stable(out_q)));

  a_r2_q_unscaled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_i, 2) == '0) |-> (out_q == $past(in_q, 2) && out_i == '0));

  a_r7_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(a_act, 2) == '0 && $past(b_act, 2) == '0)
      |-> (out_i == $past(in_i, 2) && out_q == $past(in_q, 2)));

endmodule

// File: tb/iq_balance_corr_tb.sv
module iq_balance_corr_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic coef_load = 1'b0;
  logic [31:0] coef_word = '0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  int checks = 0, errors = 0;
  int m_a = 0, m_b = 0;
  logic signed [15:0] last_i = 0, last_q = 0;
  typedef struct { logic signed [15:0] i; logic signed [15:0] q; string tag; } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  iq_balance_corr u_dut (.clk, .rst_n, .coef_load, .coef_word, .in_valid,
                         .in_i, .in_q, .out_valid, .out_i, .out_q);

  function automatic logic signed [15:0] sat16(input int x);
    if (x > 32767) return 16'sd32767;
    if (x < -32768) return -16'sd32768;
    return 16'(x);
  endfunction

  function automatic int rnd(input int c, input int x);
    int p;
    p = c * x + 16384;
    return p >>> 15;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic send(input int i, input int q, input string tag,
                      input bit ld = 0, input int a = 0, input int b = 0);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; in_i = 16'(i); in_q = 16'(q);
    coef_load = ld; coef_word = {16'(a), 16'(b)};
    it.i = sat16(i + rnd(m_a, i));
    it.q = sat16(q + rnd(m_b, i));
    it.tag = tag;
    exp_q.push_back(it);
    if (ld) begin m_a = 32'(16'(a)); m_b = 32'(16'(b)); m_a = $signed(16'(a)); m_b = $signed(16'(b)); end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; coef_load = 1'b0;
    end
  endtask

  task automatic load(input int a, input int b);
    @(negedge clk);
    in_valid = 1'b0; coef_load = 1'b1; coef_word = {16'(a), 16'(b)};
    m_a = $signed(16'(a)); m_b = $signed(16'(b));
    @(negedge clk);
    coef_load = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      item_t it;
      if (exp_q.size() == 0) begin
        check(0, "R5 unexpected out_valid", 1, 0);
      end else begin
        it = exp_q.pop_front();
        check(out_i == it.i, {it.tag, " out_i"}, out_i, it.i);
        check(out_q == it.q, {it.tag, " out_q"}, out_q, it.q);
        last_i = out_i; last_q = out_q;
      end
    end
  end

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(out_valid == 0, "R6 out_valid after reset", out_valid, 0);
    check(out_i == 0 && out_q == 0, "R6 outputs after reset", out_i, 0);
    // R7 identity with reset coefficients, back-to-back (R8)
    send(32767, -32768, "R7");
    send(-32768, 32767, "R7");
    send(1234, -4321, "R7 R8");
    send(0, 0, "R7");
    idle(4);
    // R1: A = 0.5, B = 0; R2: Q unscaled when I = 0
    load(16384, 0);
    send(1000, 7, "R1");
    send(-1001, 7, "R1");
    send(3, 0, "R1 half-LSB rounding");
    send(0, -555, "R2 I zero");
    idle(4);
    // R2: B cross-feed
    load(0, -8192);
    send(4000, 100, "R2");
    send(-4000, 100, "R2");
    send(0, 32767, "R2 I zero");
    send(1, 5, "R2 rounding");
    idle(4);
    // R3 saturation
    load(32767, 32767);
    send(32767, 32767, "R3 high");
    send(-32768, -32768, "R3 low");
    send(20000, 20000, "R3");
    idle(4);
    // R4 load in same cycle as sample: old pair applies to it
    load(0, 0);
    send(10000, 10000, "R4 old pair", 1, -16384, 16384);
    send(10000, 10000, "R4 new pair");
    send(-10000, 300, "R4 R8");
    idle(1);
    send(256, -256, "R5 gapped");
    // R5 hold while idle
    idle(6);
    check(out_valid == 0, "R5 idle valid", out_valid, 0);
    check(out_i == last_i, "R5 hold out_i", out_i, last_i);
    check(out_q == last_q, "R5 hold out_q", out_q, last_q);
    check(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule